// File: doc/BRIEF.md
# Timestamp Status Record Parser

This block consumes the payload of a timestamp status frame, delivered as a stream of 16-bit words with a frame-end marker. It splits the payload into receive, transmit and event timestamp records. Each record is decoded into fields and reported on its own output group with a one-cycle valid pulse. Every timestamp is reported as a single 64-bit nanosecond count, equal to seconds times 10^9 plus nanoseconds.

Event records may be partial, carrying only the low words of a timestamp. The block keeps the most recent full event timestamp, so a short record takes its upper words from that stored value. The stored value persists across frames. An event record also reports which external channels fired. Reported event times are reduced by a fixed input-path latency.

Parsing of a frame ends early when the block meets a record type it does not recognise, or when the frame ends in the middle of a record. The frame-end marker always returns the parser to its start state.

Top module: `tsrec_parser`

## Requirements
- R1: The first word after reset, and the first word after any word marked with in_last, is discarded and never decoded as a header.
- R2: A header word carries the record type in bits 15:12 (4'h4 event, 4'h2 receive, 4'h1 transmit) and a status field in bits 11:0. Receive and transmit records ignore the status field.
- R3: A receive record has six words after its header, in this order: ns[15:0]; a word with overflow[1:0] in bits 15:14 and ns[29:16] in bits 13:0; sec[15:0]; sec[31:16]; sequence id; then a word with the message type in bits 15:12 and the hash in bits 11:0. All of these fields appear on the rx outputs, and rx_ts = sec*10^9 + ns.
- R4: A transmit record has four words after its header (ns low, ns high, sec low, sec high). Bits 15:14 of the ns-high word are excluded from tx_ts.
- R5: In an event header's status field, bits 1:0 hold a word count N, bit 2 holds a multi-event flag and bits 5:3 hold an event number. The record body is N+1 timestamp words, with one extra channel-status word placed first when the flag is set.
- R6: An event record with count N replaces stored timestamp words 0..N (ns low, ns high, sec low, sec high) and keeps the higher words from the previous event, including one from an earlier frame. The stored words start at zero after reset.
- R7: The channel mask is the channel-status word when the multi-event flag is set and that word is nonzero. Otherwise the mask is 1 << (2*event number). ev_chan[i] equals mask bit 2*(i+1).
- R8: ev_ts equals the merged event timestamp minus EV_DELAY_NS (35 by default), taken modulo 2^64.
- R9: A header with any other type nibble stops decoding, and words are ignored until the end of the frame.
- R10: A record cut short by the end of the frame produces no output.
- R11: Each completed record produces exactly one single-cycle valid pulse on its own output group. At most one of the groups is valid in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word present |
| in_word | input | 16 | Payload word |
| in_last | input | 1 | Marks the last word of the frame |
| rx_valid | output | 1 | Receive record pulse |
| rx_ts | output | 64 | Receive timestamp in ns |
| rx_ovf | output | 2 | Receive overflow bits |
| rx_seq | output | 16 | Sequence id |
| rx_msg | output | 4 | Message type |
| rx_hash | output | 12 | Message hash |
| tx_valid | output | 1 | Transmit record pulse |
| tx_ts | output | 64 | Transmit timestamp in ns |
| ev_valid | output | 1 | Event record pulse |
| ev_ts | output | 64 | Event timestamp in ns, latency corrected |
| ev_chan | output | 6 | Channels that fired |

## Verification
The embedded assertions check several rules on every cycle. They check that the valid outputs are one-hot-or-idle and last a single cycle, and that the frame-end marker returns the sequencer to its skip state. They also check that a halted frame stays halted, that the body index stays within the record length, and that a partial event leaves the top stored word untouched. Other behaviours can only be shown by the bench's scenarios. These are the arithmetic of the nanosecond count, the latency subtraction, the choice of channel mask, the merging of partial events across frames, the skipping of a header-looking first word, and the silent dropping of unknown and truncated records.

// File: rtl/tsrec_pkg.sv
package tsrec_pkg;

    typedef logic [15:0] word_t;

    localparam int RX_WORDS    = 6;
    localparam int TX_WORDS    = 4;
    localparam int EV_TS_WORDS = 4;
    localparam int MAX_WORDS   = RX_WORDS;
    localparam int LEN_W       = $clog2(MAX_WORDS + 1);

    localparam logic [3:0] TAG_EV = 4'h4;
    localparam logic [3:0] TAG_RX = 4'h2;
    localparam logic [3:0] TAG_TX = 4'h1;

    localparam logic [63:0] NS_PER_SEC = 64'd1000000000;

    typedef enum logic [1:0] {K_NONE, K_RX, K_TX, K_EV} kind_e;
    typedef enum logic [1:0] {S_SKIP, S_HDR, S_BODY, S_HALT} state_e;

    typedef struct packed {
        logic [2:0] evnum;
        logic       multi;
        logic [1:0] cnt;
    } evhdr_t;

    function automatic evhdr_t ev_fields(input logic [11:0] st);
        evhdr_t h;
        h.evnum = st[5:3];
        h.multi = st[2];
        h.cnt   = st[1:0];
        return h;
    endfunction

    function automatic kind_e tag_kind(input logic [3:0] tag);
        case (tag)
            TAG_RX:  return K_RX;
            TAG_TX:  return K_TX;
            TAG_EV:  return K_EV;
            default: return K_NONE;
        endcase
    endfunction

    // Body length after the header; zero marks an unknown type.
    function automatic logic [LEN_W-1:0] body_len(input logic [3:0] tag,
                                                  input logic [11:0] st);
        evhdr_t h;
        h = ev_fields(st);
        case (tag)
            TAG_RX:  return LEN_W'(RX_WORDS);
            TAG_TX:  return LEN_W'(TX_WORDS);
            TAG_EV:  return LEN_W'(h.cnt) + LEN_W'(1) + LEN_W'(h.multi);
            default: return '0;
        endcase
    endfunction

    function automatic logic [63:0] stamp_ns(input word_t ns_lo, input word_t ns_hi,
                                             input word_t sec_lo, input word_t sec_hi);
        logic [63:0] s;
        s = {32'd0, sec_hi, sec_lo};
        return s * NS_PER_SEC + {34'd0, ns_hi[13:0], ns_lo};
    endfunction

endpackage

// File: rtl/tsrec_seq.sv
module tsrec_seq
    import tsrec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  word_t            in_word,
    input  logic             in_last,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_idx,
    output logic             done,
    output kind_e            kind,
    output logic [11:0]      status
);

    state_e           state;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] hdr_len;
    logic             at_end;

    assign hdr_len = body_len(in_word[15:12], in_word[11:0]);
    assign at_end  = (idx == len - LEN_W'(1));
    assign wr_en   = in_valid && (state == S_BODY);
    assign wr_idx  = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_SKIP;
            idx    <= '0;
            len    <= '0;
            kind   <= K_NONE;
            status <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_valid) begin
                case (state)
                    S_SKIP: state <= in_last ? S_SKIP : S_HDR;
                    S_HDR: begin
                        if (in_last) begin
                            state <= S_SKIP;
                        end else if (hdr_len == '0) begin
                            state <= S_HALT;
                        end else begin
                            kind   <= tag_kind(in_word[15:12]);
                            status <= in_word[11:0];
                            len    <= hdr_len;
                            idx    <= '0;
                            state  <= S_BODY;
                        end
                    end
                    S_BODY: begin
                        if (at_end) begin
                            done  <= 1'b1;
                            state <= in_last ? S_SKIP : S_HDR;
                        end else begin
                            idx <= idx + LEN_W'(1);
                            if (in_last) state <= S_SKIP;
                        end
                    end
                    default: if (in_last) state <= S_SKIP;
                endcase
            end
        end
    end

    // R9: an unknown header keeps the frame halted until its end
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT && in_valid && !in_last) |=> (state == S_HALT));

    // R1: the frame-end marker always returns to the skip state
    a_r1_frame_end_skip: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> (state == S_SKIP));

    // R5: the body index never runs past the decoded length
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        (state == S_BODY) |-> (idx < len));

    // R11: records take at least two words, so completions never touch
    a_r11_done_spacing: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/tsrec_words.sv
module tsrec_words
    import tsrec_pkg::*;
#(
    parameter int DEPTH = MAX_WORDS,
    parameter int IW    = LEN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  word_t                  wr_word,
    output logic [DEPTH-1:0][15:0] words_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                words_o[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                words_o[g] <= wr_word;
            end
        end
    end

endmodule

// File: rtl/tsrec_evstore.sv
module tsrec_evstore
    import tsrec_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         upd,
    input  logic [1:0]                   cnt,
    input  logic [EV_TS_WORDS-1:0][15:0] fresh,
    output logic [EV_TS_WORDS-1:0][15:0] merged
);

    logic [EV_TS_WORDS-1:0][15:0] st;

    for (genvar j = 0; j < EV_TS_WORDS; j++) begin : g_merge
        assign merged[j] = (j <= int'(cnt)) ? fresh[j] : st[j];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else if (upd) st <= merged;
    end

    // R6: a short event record leaves the top stored word unchanged
    a_r6_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (upd && cnt != 2'd3) |=> $stable(st[EV_TS_WORDS-1]));

    // R6: the lowest word always comes from the new record
    a_r6_low_taken: assert property (@(posedge clk) disable iff (rst)
        upd |=> (st[0] == $past(fresh[0])));

endmodule

// File: rtl/tsrec_parser.sv
module tsrec_parser
    import tsrec_pkg::*;
#(
    parameter int N_CHAN      = 6,
    parameter int EV_DELAY_NS = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    input  logic              in_last,
    output logic              rx_valid,
    output logic [63:0]       rx_ts,
    output logic [1:0]        rx_ovf,
    output logic [15:0]       rx_seq,
    output logic [3:0]        rx_msg,
    output logic [11:0]       rx_hash,
    output logic              tx_valid,
    output logic [63:0]       tx_ts,
    output logic              ev_valid,
    output logic [63:0]       ev_ts,
    output logic [N_CHAN-1:0] ev_chan
);

    logic                         wr_en;
    logic [LEN_W-1:0]             wr_idx;
    logic                         done;
    kind_e                        kind;
    logic [11:0]                  status;
    logic [MAX_WORDS-1:0][15:0]   bufw;
    logic [EV_TS_WORDS-1:0][15:0] fresh;
    logic [EV_TS_WORDS-1:0][15:0] merged;
    evhdr_t                       eh;
    word_t                        mask;
    logic [N_CHAN-1:0]            chan;
    logic                         ev_upd;

    tsrec_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_word (in_word),
        .in_last (in_last),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .done    (done),
        .kind    (kind),
        .status  (status)
    );

    tsrec_words #(.DEPTH(MAX_WORDS), .IW(LEN_W)) u_words (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_word(in_word),
        .words_o(bufw)
    );

    assign eh     = ev_fields(status);
    assign ev_upd = done && (kind == K_EV);

    for (genvar j = 0; j < EV_TS_WORDS; j++) begin : g_fresh
        assign fresh[j] = eh.multi ? bufw[j+1] : bufw[j];
    end

    tsrec_evstore u_evstore (
        .clk   (clk),
        .rst   (rst),
        .upd   (ev_upd),
        .cnt   (eh.cnt),
        .fresh (fresh),
        .merged(merged)
    );

    assign mask = (eh.multi && bufw[0] != '0) ? bufw[0]
                                              : (16'h0001 << {eh.evnum, 1'b0});

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        assign chan[i] = mask[2*(i+1)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            tx_valid <= 1'b0;
            ev_valid <= 1'b0;
            rx_ts    <= '0;
            rx_ovf   <= '0;
            rx_seq   <= '0;
            rx_msg   <= '0;
            rx_hash  <= '0;
            tx_ts    <= '0;
            ev_ts    <= '0;
            ev_chan  <= '0;
        end else begin
            rx_valid <= done && (kind == K_RX);
            tx_valid <= done && (kind == K_TX);
            ev_valid <= ev_upd;
            if (done && kind == K_RX) begin
                rx_ts   <= stamp_ns(bufw[0], bufw[1], bufw[2], bufw[3]);
                rx_ovf  <= bufw[1][15:14];
                rx_seq  <= bufw[4];
                rx_msg  <= bufw[5][15:12];
                rx_hash <= bufw[5][11:0];
            end
            if (done && kind == K_TX) begin
                tx_ts <= stamp_ns(bufw[0], bufw[1], bufw[2], bufw[3]);
            end
            if (ev_upd) begin
                ev_ts   <= stamp_ns(merged[0], merged[1], merged[2], merged[3])
                           - 64'(EV_DELAY_NS);
                ev_chan <= chan;
            end
        end
    end

    // R11: at most one output group is valid in a cycle
    a_r11_one_valid: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, tx_valid, ev_valid}));

    // R11: every valid pulse lasts exactly one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || tx_valid || ev_valid) |=> !(rx_valid || tx_valid || ev_valid));

endmodule

// File: tb/tsrec_parser_bench.sv
module tsrec_parser_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        rx_valid, tx_valid, ev_valid;
    logic [63:0] rx_ts, tx_ts, ev_ts;
    logic [1:0]  rx_ovf;
    logic [15:0] rx_seq;
    logic [3:0]  rx_msg;
    logic [11:0] rx_hash;
    logic [5:0]  ev_chan;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [97:0] rx_q[$];
    logic [63:0] tx_q[$];
    logic [69:0] ev_q[$];
    logic [15:0] ev_m[4] = '{16'h0, 16'h0, 16'h0, 16'h0};
    logic        any_prev = 1'b0;

    always #4 clk = ~clk;

    tsrec_parser u_tsrec_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_last(in_last),
        .rx_valid(rx_valid), .rx_ts(rx_ts), .rx_ovf(rx_ovf), .rx_seq(rx_seq),
        .rx_msg(rx_msg), .rx_hash(rx_hash), .tx_valid(tx_valid), .tx_ts(tx_ts),
        .ev_valid(ev_valid), .ev_ts(ev_ts), .ev_chan(ev_chan)
    );

    function automatic logic [63:0] ref_ns(input logic [15:0] nl, input logic [15:0] nh,
                                           input logic [15:0] sl, input logic [15:0] sh);
        logic [63:0] sec;
        sec = {32'd0, sh, sl};
        return sec * 64'd1000000000 + {34'd0, nh[13:0], nl};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                checks++;
                if (rx_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 R3 unexpected rx record act=%h exp=none", rx_ts);
                end else begin
                    logic [97:0] e;
                    e = rx_q.pop_front();
                    if ({rx_ts, rx_ovf, rx_seq, rx_msg, rx_hash} !== e) begin
                        errors++;
                        $display("FAIL R3 rx fields act=%h exp=%h",
                                 {rx_ts, rx_ovf, rx_seq, rx_msg, rx_hash}, e);
                    end
                end
            end
            if (tx_valid) begin
                checks++;
                if (tx_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 R4 unexpected tx record act=%h exp=none", tx_ts);
                end else begin
                    logic [63:0] e;
                    e = tx_q.pop_front();
                    if (tx_ts !== e) begin
                        errors++;
                        $display("FAIL R4 tx_ts act=%h exp=%h", tx_ts, e);
                    end
                end
            end
            if (ev_valid) begin
                checks++;
                if (ev_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 R5 unexpected event act=%h exp=none", ev_ts);
                end else begin
                    logic [69:0] e;
                    e = ev_q.pop_front();
                    if ({ev_ts, ev_chan} !== e) begin
                        errors++;
                        $display("FAIL R6 R7 R8 event act=%h exp=%h", {ev_ts, ev_chan}, e);
                    end
                end
            end
            if (any_prev && (rx_valid || tx_valid || ev_valid)) begin
                checks++;
                errors++;
                $display("FAIL R11 valid on consecutive cycles act=1 exp=0");
            end
            any_prev = rx_valid || tx_valid || ev_valid;
        end
    end

    task automatic put(input logic [15:0] w, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_last  = last;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic send_rx(input logic [15:0] nl, input logic [15:0] nh, input logic [15:0] sl,
                           input logic [15:0] sh, input logic [15:0] sq, input logic [15:0] mw,
                           input bit last);
        rx_q.push_back({ref_ns(nl, nh, sl, sh), nh[15:14], sq, mw[15:12], mw[11:0]});
        put(16'h2ABC, 1'b0);   // R2: status bits ignored for receive
        put(nl, 1'b0); put(nh, 1'b0); put(sl, 1'b0); put(sh, 1'b0);
        put(sq, 1'b0); put(mw, last);
    endtask

    task automatic send_tx(input logic [15:0] nl, input logic [15:0] nh, input logic [15:0] sl,
                           input logic [15:0] sh, input bit last);
        tx_q.push_back(ref_ns(nl, nh, sl, sh));
        put(16'h1FFF, 1'b0);
        put(nl, 1'b0); put(nh, 1'b0); put(sl, 1'b0); put(sh, last);
    endtask

    task automatic send_ev(input logic [1:0] cnt, input bit multi, input logic [2:0] evn,
                           input logic [15:0] stw, input logic [15:0] w0, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3, input bit last);
        logic [15:0] w[4];
        logic [15:0] mask;
        logic [5:0]  ch;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        for (int j = 0; j <= int'(cnt); j++) ev_m[j] = w[j];
        mask = (multi && stw != 0) ? stw : (16'h1 << (2 * evn));
        for (int i = 0; i < 6; i++) ch[i] = mask[2 * i + 2];
        ev_q.push_back({ref_ns(ev_m[0], ev_m[1], ev_m[2], ev_m[3]) - 64'd35, ch});
        put({4'h4, 6'd0, evn, multi, cnt}, 1'b0);
        if (multi) put(stw, (cnt == 0) ? 1'b0 : 1'b0);
        for (int j = 0; j <= int'(cnt); j++) put(w[j], last && (j == int'(cnt)));
    endtask

    task automatic check_drained(input string tag);
        idle(4);
        checks++;
        if (rx_q.size() + tx_q.size() + ev_q.size() != 0) begin
            errors++;
            $display("FAIL %s records missing act=%0d exp=0", tag,
                     rx_q.size() + tx_q.size() + ev_q.size());
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state, no valid pulses
        checks++;
        if (rx_valid || tx_valid || ev_valid) begin
            errors++;
            $display("FAIL R11 reset valids act=%b exp=000", {rx_valid, tx_valid, ev_valid});
        end

        // R1: the skip word looks like a transmit header and must be ignored
        put(16'h1000, 1'b0);
        send_rx(16'h1234, 16'h8005, 16'h0001, 16'h0000, 16'hBEEF, 16'h3ABC, 1'b0);
        send_tx(16'hFFFF, 16'hC001, 16'h0010, 16'h0000, 1'b0);   // R4 overflow masked
        send_ev(2'd3, 1'b0, 3'd2, 16'h0, 16'h0100, 16'h0002, 16'h0005, 16'h0000, 1'b1);
        check_drained("R1");

        // R6: partial event keeps seconds from the previous frame's event
        put(16'h0000, 1'b0);
        send_ev(2'd1, 1'b0, 3'd6, 16'h0, 16'h0040, 16'h0001, 16'h0, 16'h0, 1'b0);
        send_tx(16'h0007, 16'h0000, 16'h0003, 16'h0001, 1'b1);
        check_drained("R6");

        // R5 R7: multi-event word used, then zero word falls back to event number
        put(16'h4444, 1'b0);
        send_ev(2'd0, 1'b1, 3'd1, 16'h0014, 16'h0022, 16'h0, 16'h0, 16'h0, 1'b0);
        send_ev(2'd2, 1'b1, 3'd3, 16'h0000, 16'h0011, 16'h0003, 16'h0009, 16'h0, 1'b0);
        send_tx(16'h0100, 16'h0000, 16'h0000, 16'h0000, 1'b1);
        check_drained("R5");

        // R9: unknown type halts the rest of the frame
        put(16'h0000, 1'b0);
        put(16'h3000, 1'b0);
        put(16'h1000, 1'b0); put(16'h0001, 1'b0); put(16'h0002, 1'b0);
        put(16'h0003, 1'b0); put(16'h0004, 1'b1);
        check_drained("R9");
        put(16'h0000, 1'b0);
        send_tx(16'h0055, 16'h0000, 16'h0002, 16'h0000, 1'b1);
        check_drained("R9");

        // R10: truncated transmit record yields nothing, next frame restarts
        put(16'h0000, 1'b0);
        put(16'h1000, 1'b0); put(16'h0001, 1'b0); put(16'h0002, 1'b1);
        check_drained("R10");
        put(16'h2000, 1'b0);   // R1: skip word after frame end
        send_rx(16'h0000, 16'h4000, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hF000, 1'b1);
        check_drained("R10");

        // R8 R7: small timestamp, event number zero maps to no channel
        put(16'h0000, 1'b0);
        send_ev(2'd3, 1'b0, 3'd0, 16'h0, 16'd40, 16'h0000, 16'h0000, 16'h0000, 1'b0);
        send_ev(2'd3, 1'b0, 3'd7, 16'h0, 16'd10, 16'h0000, 16'h0000, 16'h0000, 1'b1);
        check_drained("R8");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule